// File: doc/BRIEF.md
# MAC Address Range Expander

The block turns a compact address record into the list of MAC addresses it stands for. The record lives in a small byte-addressed memory. It holds a six-byte base address followed by one count byte. After a start pulse the block reads the seven record bytes through a synchronous read port whose data arrives one cycle after the strobe. It then presents the assigned addresses one at a time on a valid/ready output, each tagged with its position in the list.

Every address after the first keeps the upper five bytes of the base address. Its lowest byte is the base's lowest byte plus the list position. The record's count decides how many addresses come out; the nominal value is eight. A count of zero gives an empty list. A record whose lowest byte would step past 0xFF gives an error flag and no addresses, so no wrapped address ever leaves the block. A single-cycle done pulse closes every scan, whatever its outcome.

Top module: `mac_range_expander`

## Requirements
- R1: A start sampled at clock edge 0 while the block is idle makes `mem_rd` high for exactly seven consecutive cycles, from edge 0 to edge 7, with `mem_addr` equal to BASE_ADDR+0, +1, ... +6 in that order. The read data for each strobe is taken in the following cycle.
- R2: The byte at offset 0 becomes bits 47:40 of the base address and the byte at offset 5 becomes bits 7:0. The bytes at offsets 1 to 4 fill the bits in between, in descending order.
- R3: With a non-zero count and no overflow, `out_valid` rises in the cycle that follows edge 9. The first entry has `out_idx` = 0 and `out_mac` equal to the stored base address.
- R4: The entry with index i carries bits 47:8 of the base unchanged and bits 7:0 equal to the base's low byte plus i.
- R5: The count is the byte at offset 6, and exactly that many handshakes (`out_valid` and `out_ready` both high at a clock edge) occur per scan.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_mac` and `out_idx` hold their values into the next cycle.
- R7: `out_idx` advances by one only at a completed handshake.
- R8: After the handshake of the last entry, `out_valid` falls and `done` is high for exactly one cycle.
- R9: A count of zero produces no `out_valid`. `done` pulses in the cycle that follows edge 9.
- R10: If low byte + count − 1 exceeds 255, `ovf_err` rises in the cycle that follows edge 9 and `done` pulses in that same cycle. No entry is emitted. `ovf_err` stays high until the next accepted start clears it. A sum of exactly 255 is valid.
- R11: A start that arrives between its acceptance edge and the last handshake of an emitting scan is ignored. The same holds between acceptance and the done pulse of an empty or overflowing scan. Such a start causes no further reads and no change to the list.
- R12: After reset, `mem_rd`, `out_valid`, `done` and `ovf_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a new scan (ignored while busy) |
| mem_addr | output | AW | Byte address of the record read |
| mem_rd | output | 1 | Read strobe, data due one cycle later |
| mem_rdata | input | 8 | Read data |
| out_mac | output | 48 | Current MAC address |
| out_idx | output | 8 | Position of the current address in the list |
| out_valid | output | 1 | Current address is offered |
| out_ready | input | 1 | Consumer takes the current address |
| done | output | 1 | One-cycle end-of-scan pulse |
| ovf_err | output | 1 | Low-byte overflow detected in the last scan |

## Verification
Counted from the edge that samples an accepted start, the read strobes are due from edge 0 to edge 7. The outcome of the scan (first entry, empty-list done or overflow) is due right after edge 9. Each later entry or the final done pulse is due one cycle after the handshake that precedes it. The bench model steps through these same delays with a phase counter and predicts the next cycle's outputs from the inputs held during the current one. It compares every output at the falling edge, half a cycle away from the edges where the design and the stimulus change.

// File: rtl/mre_pkg.sv
// Shared constants and state types for the MAC range expander.
// Assumes a record of six address bytes plus one count byte.
package mre_pkg;
    localparam int MAC_BYTES = 6;
    localparam int REC_BYTES = MAC_BYTES + 1;
    localparam int MAC_W     = MAC_BYTES * 8;

    typedef enum logic [1:0] {
        RD_IDLE,
        RD_ISSUE,
        RD_DRAIN,
        RD_PUB
    } rd_state_t;
endpackage

// File: rtl/mre_reader.sv
// Record reader: issues one read per cycle over the seven record bytes,
// captures each byte one cycle after its strobe and publishes base and
// count with a one-cycle pulse. Assumes the memory keeps the record
// unchanged during a scan.
module mre_reader
    import mre_pkg::*;
#(
    parameter int AW        = 8,
    parameter int BASE_ADDR = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    output logic [AW-1:0]    mem_addr,
    output logic             mem_rd,
    input  logic [7:0]       mem_rdata,
    output logic             busy,
    output logic             rec_vld,
    output logic [MAC_W-1:0] rec_base,
    output logic [7:0]       rec_cnt
);
    localparam int PW = $clog2(REC_BYTES);
    localparam logic [PW-1:0] LAST = PW'(REC_BYTES - 1);

    rd_state_t      state;
    logic [PW-1:0]  ptr;
    logic           cap_vld;
    logic [PW-1:0]  cap_idx;

    // Strobe and address follow the issue pointer.
    always_comb begin
        mem_rd   = (state == RD_ISSUE);
        mem_addr = AW'(BASE_ADDR) + AW'(ptr);
        busy     = (state != RD_IDLE);
        rec_vld  = (state == RD_PUB);
    end

    // Sequence the reads and shift returning bytes into the record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= RD_IDLE;
            ptr      <= '0;
            cap_vld  <= 1'b0;
            cap_idx  <= '0;
            rec_base <= '0;
            rec_cnt  <= '0;
        end else begin
            cap_vld <= (state == RD_ISSUE);
            cap_idx <= ptr;
            case (state)
                RD_IDLE: if (go) begin
                    state <= RD_ISSUE;
                    ptr   <= '0;
                end
                RD_ISSUE: if (ptr == LAST) state <= RD_DRAIN;
                          else             ptr   <= ptr + 1'b1;
                RD_DRAIN: if (cap_vld && cap_idx == LAST) state <= RD_PUB;
                default:  state <= RD_IDLE;
            endcase
            if (cap_vld) begin
                if (cap_idx == LAST) rec_cnt  <= mem_rdata;
                else                 rec_base <= {rec_base[MAC_W-9:0], mem_rdata};
            end
        end
    end
endmodule

// File: rtl/mre_emitter.sv
// List emitter: on a published record, checks the count and the low-byte
// range, then offers base+i for i in 0..count-1 over valid/ready.
// Assumes rec_vld is a single-cycle pulse.
module mre_emitter
    import mre_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             rec_vld,
    input  logic [MAC_W-1:0] rec_base,
    input  logic [CW-1:0]    rec_cnt,
    input  logic             out_ready,
    output logic [MAC_W-1:0] out_mac,
    output logic [CW-1:0]    out_idx,
    output logic             out_valid,
    output logic             done,
    output logic             ovf_err,
    output logic             busy
);
    localparam int SW = CW + 2;

    logic [MAC_W-1:0] base_q;
    logic [CW-1:0]    cnt_q;
    logic [SW-1:0]    reach;
    logic             too_far;

    // Low byte plus count beyond 256 means the last entry would wrap.
    always_comb begin
        reach   = SW'(rec_base[7:0]) + SW'(rec_cnt);
        too_far = (reach > SW'(256));
        out_mac = {base_q[MAC_W-1:8], base_q[7:0] + 8'(out_idx)};
        busy    = out_valid;
    end

    // Load the record, then advance through the list on handshakes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q    <= '0;
            cnt_q     <= '0;
            out_idx   <= '0;
            out_valid <= 1'b0;
            done      <= 1'b0;
            ovf_err   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (clr) ovf_err <= 1'b0;
            if (rec_vld) begin
                base_q  <= rec_base;
                cnt_q   <= rec_cnt;
                out_idx <= '0;
                if (rec_cnt == '0) begin
                    done <= 1'b1;
                end else if (too_far) begin
                    ovf_err <= 1'b1;
                    done    <= 1'b1;
                end else begin
                    out_valid <= 1'b1;
                end
            end else if (out_valid && out_ready) begin
                if (out_idx == cnt_q - 1'b1) begin
                    out_valid <= 1'b0;
                    done      <= 1'b1;
                end else begin
                    out_idx <= out_idx + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mac_range_expander.sv
// Top: reads a base MAC and a count from a byte memory and emits the
// range base..base+count-1 (low byte stepped). A start is accepted only
// when both the reader and the emitter are idle.
module mac_range_expander
    import mre_pkg::*;
#(
    parameter int AW        = 8,
    parameter int BASE_ADDR = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic [AW-1:0]    mem_addr,
    output logic             mem_rd,
    input  logic [7:0]       mem_rdata,
    output logic [MAC_W-1:0] out_mac,
    output logic [7:0]       out_idx,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             done,
    output logic             ovf_err
);
    logic             rd_busy;
    logic             em_busy;
    logic             accept;
    logic             rec_vld;
    logic [MAC_W-1:0] rec_base;
    logic [7:0]       rec_cnt;

    // Gate the start with both stages' activity.
    assign accept = start && !rd_busy && !em_busy;

    mre_reader #(.AW(AW), .BASE_ADDR(BASE_ADDR)) u_reader (
        .clk(clk), .rst_n(rst_n), .go(accept),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
        .busy(rd_busy), .rec_vld(rec_vld), .rec_base(rec_base), .rec_cnt(rec_cnt)
    );

    mre_emitter #(.CW(8)) u_emitter (
        .clk(clk), .rst_n(rst_n), .clr(accept),
        .rec_vld(rec_vld), .rec_base(rec_base), .rec_cnt(rec_cnt),
        .out_ready(out_ready), .out_mac(out_mac), .out_idx(out_idx),
        .out_valid(out_valid), .done(done), .ovf_err(ovf_err), .busy(em_busy)
    );
endmodule

// File: rtl/mre_checker.sv
// Port-level property checker for mac_range_expander, attached by bind.
module mre_checker #(
    parameter int AW        = 8,
    parameter int BASE_ADDR = 0
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] mem_addr,
    input logic          mem_rd,
    input logic [47:0]   out_mac,
    input logic [7:0]    out_idx,
    input logic          out_valid,
    input logic          out_ready,
    input logic          done,
    input logic          ovf_err
);
    a_r1_addr_in_record: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (int'(mem_addr) >= BASE_ADDR && int'(mem_addr) <= BASE_ADDR + 6));

    a_r3_first_index_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> out_idx == 8'd0);

    a_r4_upper_bytes_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |-> out_mac[47:8] == $past(out_mac[47:8]));

    a_r6_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_mac) && $stable(out_idx)));

    a_r7_index_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> (done || (out_valid && out_idx == $past(out_idx) + 8'd1)));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_done_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !out_valid);

    a_r10_no_emit_on_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |-> !out_valid);

    a_r11_no_read_while_emit: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !mem_rd);
endmodule

bind mac_range_expander mre_checker #(.AW(AW), .BASE_ADDR(BASE_ADDR)) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .out_mac(out_mac), .out_idx(out_idx), .out_valid(out_valid),
    .out_ready(out_ready), .done(done), .ovf_err(ovf_err)
);

// File: tb/mac_range_expander_tb_top.sv
module mac_range_expander_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  mem_addr;
    logic        mem_rd;
    logic [7:0]  mem_rdata = 8'h00;
    logic [47:0] out_mac;
    logic [7:0]  out_idx;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic        done;
    logic        ovf_err;

    always #4 clk = ~clk;

    mac_range_expander dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
        .out_mac(out_mac), .out_idx(out_idx), .out_valid(out_valid),
        .out_ready(out_ready), .done(done), .ovf_err(ovf_err)
    );

    int n_chk = 0;
    int n_err = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Record memory, one-cycle read latency.
    logic [7:0] mem [0:7];
    always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[2:0]];

    // Consumer ready pattern.
    int mode = 0;
    int rc = 0;
    always @(posedge clk) begin
        #2;
        rc = rc + 1;
        out_ready = (mode == 0) ? 1'b1 : ((rc % 3) != 0);
    end

    // Reference model state: predicted outputs for the current cycle.
    int          ms = 0, mk = 0, mw = 0;
    bit          m_rd = 0, m_valid = 0, m_done = 0, m_ovf = 0;
    int          m_addr = 0, m_idx = 0, m_cnt = 0;
    logic [47:0] m_base = '0;
    bit          mon_en = 0;

    // Scan bookkeeping.
    int          hs_cnt = 0, rd_cnt = 0;
    bit          seen_done = 0;
    logic [47:0] first_mac = '0, last_mac = '0, prev_mac = '0;
    bit          prev_stall = 0;

    always @(negedge clk) begin
        if (mon_en) begin
            chk(mem_rd == m_rd, "R1 mem_rd", 64'(mem_rd), 64'(m_rd));
            if (m_rd) chk(int'(mem_addr) == m_addr, "R1 mem_addr", 64'(mem_addr), 64'(m_addr));
            chk(out_valid == m_valid, (m_cnt == 0) ? "R9 out_valid" : "R5 out_valid", 64'(out_valid), 64'(m_valid));
            if (m_valid && out_valid) begin
                chk(int'(out_idx) == m_idx, "R7 out_idx", 64'(out_idx), 64'(m_idx));
                chk(out_mac == {m_base[47:8], m_base[7:0] + 8'(m_idx)}, "R4 out_mac",
                    64'(out_mac), 64'({m_base[47:8], m_base[7:0] + 8'(m_idx)}));
            end
            chk(done == m_done, "R8 done", 64'(done), 64'(m_done));
            chk(ovf_err == m_ovf, "R10 ovf_err", 64'(ovf_err), 64'(m_ovf));

            if (prev_stall && out_valid)
                chk(out_mac == prev_mac, "R6 hold", 64'(out_mac), 64'(prev_mac));
            prev_stall = out_valid && !out_ready;
            prev_mac   = out_mac;
            if (mem_rd) rd_cnt++;
            if (done) seen_done = 1;
            if (out_valid && out_ready) begin
                hs_cnt++;
                if (hs_cnt == 1) first_mac = out_mac;
                last_mac = out_mac;
            end

            // Predict the next cycle from the inputs held now.
            m_done = 0;
            case (ms)
                0: begin
                    m_rd = 0;
                    if (start) begin
                        ms = 1; mk = 0; m_rd = 1; m_addr = 0; m_ovf = 0;
                    end
                end
                1: begin
                    if (mk < 6) begin mk++; m_addr = mk; end
                    else begin m_rd = 0; ms = 2; mw = 2; end
                end
                2: begin
                    if (mw > 1) mw--;
                    else begin
                        m_base = {mem[0], mem[1], mem[2], mem[3], mem[4], mem[5]};
                        m_cnt  = int'(mem[6]);
                        if (m_cnt == 0) begin m_done = 1; ms = 0; end
                        else if (int'(m_base[7:0]) + m_cnt - 1 > 255) begin
                            m_ovf = 1; m_done = 1; ms = 0;
                        end else begin
                            m_valid = 1; m_idx = 0; ms = 3;
                        end
                    end
                end
                default: begin
                    if (out_ready) begin
                        if (m_idx == m_cnt - 1) begin m_valid = 0; m_done = 1; ms = 0; end
                        else m_idx++;
                    end
                end
            endcase
        end
    end

    task automatic pulse_start();
        @(posedge clk); #2 start = 1'b1;
        @(posedge clk); #2 start = 1'b0;
    endtask

    task automatic scan(input logic [47:0] base, input int cnt, input int rmode, input bit extra);
        for (int i = 0; i < 6; i++) mem[i] = base[47 - 8*i -: 8];
        mem[6] = 8'(cnt);
        mode = rmode;
        hs_cnt = 0; rd_cnt = 0; seen_done = 0;
        pulse_start();
        if (extra) begin
            repeat (2) @(posedge clk);
            pulse_start();
            repeat (8) @(posedge clk);
            pulse_start();
        end
        while (!seen_done) @(negedge clk);
        repeat (2) @(negedge clk);
        begin
            bit ovf_exp = (cnt > 0) && (int'(base[7:0]) + cnt - 1 > 255);
            int n_exp = (cnt == 0 || ovf_exp) ? 0 : cnt;
            chk(hs_cnt == n_exp, "R5 entries", 64'(hs_cnt), 64'(n_exp));
            chk(rd_cnt == 7, extra ? "R11 reads" : "R1 reads", 64'(rd_cnt), 64'd7);
            chk(ovf_err == ovf_exp, "R10 flag", 64'(ovf_err), 64'(ovf_exp));
            if (cnt == 0) chk(hs_cnt == 0, "R9 empty", 64'(hs_cnt), 64'd0);
            if (n_exp > 0) begin
                chk(first_mac == base, "R3 first", 64'(first_mac), 64'(base));
                chk(last_mac == {base[47:8], base[7:0] + 8'(cnt - 1)}, "R4 last",
                    64'(last_mac), 64'({base[47:8], base[7:0] + 8'(cnt - 1)}));
            end
        end
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(!mem_rd && !out_valid && !done && !ovf_err, "R12 reset",
            64'({mem_rd, out_valid, done, ovf_err}), 64'd0);
        @(posedge clk); #2 rst_n = 1'b1;
        mon_en = 1;

        scan(48'h644C360F4430, 8, 0, 0);
        chk(first_mac[47:40] == 8'h64 && first_mac[7:0] == 8'h30, "R2 order",
            64'(first_mac), 64'h644C360F4430);
        scan(48'h0A1B2C3D4E10, 8, 1, 1);
        scan(48'h112233445566, 0, 0, 0);
        scan(48'hA0B0C0D0E0F8, 8, 1, 0);
        scan(48'hA0B0C0D0E0F9, 8, 0, 0);
        repeat (5) @(negedge clk);
        chk(ovf_err == 1'b1, "R10 sticky", 64'(ovf_err), 64'd1);
        scan(48'h0102030405AA, 1, 1, 0);
        scan(48'h00000000FF00, 255, 0, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule